// File: doc/BRIEF.md
# DS2 Time-Slot Source Selector

This block decides, for each of seven DS2 time slots carried in an outgoing DS3, which bit stream fills that slot. There are three candidate sources for slot y. The first is the same slot y taken from the received DS3, which loops it back. The second is the output of the local M12 multiplexer for that slot. The third is a DS2 stream supplied directly from outside. A fixed priority picks the source for each slot. Automatic loopback wins when it is enabled globally and the slot has its loopback-detected flag set. A forced loopback bit for the slot comes next. After that, a 2-bit mode field chooses between the multiplexer output and the external stream. While the transmitter runs in C-bit parity mode, both loopback paths are blocked.

The chosen source is held in a register. It is re-evaluated only on a cycle where the DS3 frame boundary strobe is high, so a slot never changes source partway through a frame. For each slot the block drives the selected data bit and a 2-bit code that names the source in use.

Top module: `ds2_slot_selector`

## Requirements
- R1: While reset is asserted, every slot's source code is 0 (M12) and every selected data bit is 0.
- R2: On a strobe cycle with auto_lb_en=1, lb_det bit y=1 and cbit_mode=0, slot y takes source code 2 (automatic loopback) and its data comes from rx_slot_data bit y.
- R3: On a strobe cycle with cbit_mode=0, force_lb bit y=1 and automatic loopback not active for slot y, slot y takes source code 3 (forced loopback) and its data comes from rx_slot_data bit y.
- R4: When the automatic and forced loopback conditions both hold for a slot on a strobe cycle, that slot reports code 2.
- R5: On a strobe cycle with no loopback active for slot y, a mode field (slot_mode bits 2(y-1)+1 down to 2(y-1)) of 00 gives code 0 and data from m12_data bit y.
- R6: On a strobe cycle with no loopback active for slot y, a mode field of 01, 10 or 11 gives code 1 and data from ext_ds2_data bit y.
- R7: On a strobe cycle with cbit_mode=1, the loopback flags have no effect, and each slot's code follows its mode field as in R5 and R6.
- R8: Control inputs sampled on a cycle without the strobe have no effect, and every source code keeps its value.
- R9: On every clock edge, sel_data bit y is loaded from the input that the code for slot y selects after that same edge. The data output therefore follows its inputs by one cycle.
- R10: Slots are independent. Slot y (y = 1..7) uses bit y-1 of every per-slot vector and bits 2(y-1)+1 down to 2(y-1) of src_code, with no influence between slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_strobe | input | 1 | DS3 frame boundary; source choice is updated on this cycle |
| auto_lb_en | input | 1 | Global enable for automatic loopback |
| lb_det | input | 7 | Per-slot loopback-detected flags |
| force_lb | input | 7 | Per-slot forced loopback bits |
| slot_mode | input | 14 | Per-slot 2-bit mode field, 00 = M12 output, else external |
| cbit_mode | input | 1 | C-bit parity mode; blocks all loopback |
| rx_slot_data | input | 7 | Per-slot bits from the received DS3 |
| m12_data | input | 7 | Per-slot bits from the local M12 multiplexers |
| ext_ds2_data | input | 7 | Per-slot external DS2 bits |
| sel_data | output | 7 | Registered selected bit per slot |
| src_code | output | 14 | Registered 2-bit source code per slot: 0 M12, 1 external, 2 auto loopback, 3 forced loopback |

## Verification
A strobe and its controls, driven before an edge, show up in src_code right after that edge. The data bits present before that same edge appear in sel_data at the same moment, already routed through the new choice. Any input change therefore shows at the outputs exactly one edge later. The driver applies each stimulus half a period before the edge and queues the value it predicts for that edge. The monitor then reads the outputs a quarter period after the edge and compares them in queue order. Steps that carry changed controls but no strobe confirm that the codes hold while the data keeps following the old source.

// File: rtl/ds2sel_pkg.sv
package ds2sel_pkg;

    typedef enum logic [1:0] {
        SRC_M12   = 2'd0,
        SRC_EXT   = 2'd1,
        SRC_AUTO  = 2'd2,
        SRC_FORCE = 2'd3
    } src_e;

    localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/ds2sel_slot_decode.sv
module ds2sel_slot_decode
    import ds2sel_pkg::*;
(
    input  logic              auto_en,
    input  logic              det,
    input  logic              force_lb,
    input  logic              cbit_mode,
    input  logic [MODE_W-1:0] mode,
    output src_e              src
);

    logic lb_allowed;

    assign lb_allowed = !cbit_mode;

    always_comb begin
        if (lb_allowed && auto_en && det) begin
            src = SRC_AUTO;
        end else if (lb_allowed && force_lb) begin
            src = SRC_FORCE;
        end else if (mode == '0) begin
            src = SRC_M12;
        end else begin
            src = SRC_EXT;
        end
    end

endmodule

// File: rtl/ds2sel_slot_mux.sv
module ds2sel_slot_mux
    import ds2sel_pkg::*;
(
    input  src_e src,
    input  logic m12_bit,
    input  logic ext_bit,
    input  logic rx_bit,
    output logic out_bit
);

    always_comb begin
        unique case (src)
            SRC_M12:   out_bit = m12_bit;
            SRC_EXT:   out_bit = ext_bit;
            default:   out_bit = rx_bit;
        endcase
    end

endmodule

// File: rtl/ds2_slot_selector.sv
module ds2_slot_selector
    import ds2sel_pkg::*;
#(
    parameter int unsigned N_SLOTS = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_strobe,
    input  logic                      auto_lb_en,
    input  logic [N_SLOTS-1:0]        lb_det,
    input  logic [N_SLOTS-1:0]        force_lb,
    input  logic [N_SLOTS*MODE_W-1:0] slot_mode,
    input  logic                      cbit_mode,
    input  logic [N_SLOTS-1:0]        rx_slot_data,
    input  logic [N_SLOTS-1:0]        m12_data,
    input  logic [N_SLOTS-1:0]        ext_ds2_data,
    output logic [N_SLOTS-1:0]        sel_data,
    output logic [N_SLOTS*2-1:0]      src_code
);

    localparam int unsigned CODE_W = $bits(src_e);

    typedef struct packed {
        src_e [N_SLOTS-1:0] src;
        logic [N_SLOTS-1:0] data;
    } state_t;

    state_t             state_d;
    state_t             state_q;
    src_e [N_SLOTS-1:0] dec_src;
    src_e [N_SLOTS-1:0] src_nxt;
    logic [N_SLOTS-1:0] pick;

    // Per-slot priority decode and data pick
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        ds2sel_slot_decode u_dec (
            .auto_en   (auto_lb_en),
            .det       (lb_det[g]),
            .force_lb  (force_lb[g]),
            .cbit_mode (cbit_mode),
            .mode      (slot_mode[g*MODE_W +: MODE_W]),
            .src       (dec_src[g])
        );

        ds2sel_slot_mux u_mux (
            .src     (src_nxt[g]),
            .m12_bit (m12_data[g]),
            .ext_bit (ext_ds2_data[g]),
            .rx_bit  (rx_slot_data[g]),
            .out_bit (pick[g])
        );

        assign src_code[g*CODE_W +: CODE_W] = state_q.src[g];
    end

    // Source choice moves only on a frame boundary
    always_comb begin
        for (int i = 0; i < N_SLOTS; i++) begin
            src_nxt[i] = frame_strobe ? dec_src[i] : state_q.src[i];
        end
    end

    always_comb begin
        state_d      = state_q;
        state_d.src  = src_nxt;
        state_d.data = pick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SLOTS; i++) begin
                state_q.src[i] <= SRC_M12;
            end
            state_q.data <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sel_data = state_q.data;

endmodule

// File: rtl/ds2sel_checker.sv
module ds2sel_checker
    import ds2sel_pkg::*;
#(
    parameter int unsigned N_SLOTS = 7
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      frame_strobe,
    input logic                      auto_lb_en,
    input logic [N_SLOTS-1:0]        lb_det,
    input logic [N_SLOTS-1:0]        force_lb,
    input logic [N_SLOTS*MODE_W-1:0] slot_mode,
    input logic                      cbit_mode,
    input logic [N_SLOTS-1:0]        rx_slot_data,
    input logic [N_SLOTS-1:0]        m12_data,
    input logic [N_SLOTS-1:0]        ext_ds2_data,
    input logic [N_SLOTS-1:0]        sel_data,
    input logic [N_SLOTS*2-1:0]      src_code
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    function automatic logic route(input logic [1:0] c, input logic m, input logic e, input logic r);
        if (c == 2'd0)      return m;
        else if (c == 2'd1) return e;
        else                return r;
    endfunction

    // R8: no strobe, codes hold
    a_r8_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |=> $stable(src_code));

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_chk
        // R2 and R4: automatic loopback has top priority
        a_r2_auto_loop: assert property (@(posedge clk) disable iff (!rst_n)
            frame_strobe && auto_lb_en && lb_det[g] && !cbit_mode
            |=> src_code[2*g +: 2] == 2'd2);

        // R3: forced loopback
        a_r3_forced_loop: assert property (@(posedge clk) disable iff (!rst_n)
            frame_strobe && !cbit_mode && force_lb[g] && !(auto_lb_en && lb_det[g])
            |=> src_code[2*g +: 2] == 2'd3);

        // R5 and R7: mode 00 picks M12
        a_r5_m12_pick: assert property (@(posedge clk) disable iff (!rst_n)
            frame_strobe && (cbit_mode || !(force_lb[g] || (auto_lb_en && lb_det[g])))
            && slot_mode[2*g +: 2] == 2'b00
            |=> src_code[2*g +: 2] == 2'd0);

        // R6 and R7: any other mode picks the external stream
        a_r6_ext_pick: assert property (@(posedge clk) disable iff (!rst_n)
            frame_strobe && (cbit_mode || !(force_lb[g] || (auto_lb_en && lb_det[g])))
            && slot_mode[2*g +: 2] != 2'b00
            |=> src_code[2*g +: 2] == 2'd1);

        // R9: data follows the held code with one cycle of latency
        a_r9_data_route: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok |-> sel_data[g] == route(src_code[2*g +: 2], $past(m12_data[g]),
                                             $past(ext_ds2_data[g]), $past(rx_slot_data[g])));
    end

endmodule

bind ds2_slot_selector ds2sel_checker #(.N_SLOTS(N_SLOTS)) u_ds2sel_chk (.*);

// File: tb/test_ds2_slot_selector.sv
module test_ds2_slot_selector;

    localparam int N = 7;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           frame_strobe = 1'b0;
    logic           auto_lb_en = 1'b0;
    logic [N-1:0]   lb_det = '0;
    logic [N-1:0]   force_lb = '0;
    logic [2*N-1:0] slot_mode = '0;
    logic           cbit_mode = 1'b0;
    logic [N-1:0]   rx_slot_data = '0;
    logic [N-1:0]   m12_data = '0;
    logic [N-1:0]   ext_ds2_data = '0;
    logic [N-1:0]   sel_data;
    logic [2*N-1:0] src_code;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    typedef struct {
        logic [2*N-1:0] code;
        logic [N-1:0]   data;
        string          req;
    } item_t;

    item_t sb_q[$];
    int    exp_src[N];

    always #10 clk = ~clk;

    ds2_slot_selector #(.N_SLOTS(N)) i_ds2_slot_selector (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_strobe (frame_strobe),
        .auto_lb_en   (auto_lb_en),
        .lb_det       (lb_det),
        .force_lb     (force_lb),
        .slot_mode    (slot_mode),
        .cbit_mode    (cbit_mode),
        .rx_slot_data (rx_slot_data),
        .m12_data     (m12_data),
        .ext_ds2_data (ext_ds2_data),
        .sel_data     (sel_data),
        .src_code     (src_code)
    );

    task automatic compare(input string req, input logic [2*N-1:0] ec, input logic [N-1:0] ed);
        compared++;
        if (src_code !== ec || sel_data !== ed) begin
            mismatched++;
            $display("FAIL %s: code=%h data=%b expected code=%h data=%b",
                     req, src_code, sel_data, ec, ed);
        end
    endtask

    // Driver: apply a stimulus and queue the prediction for the next edge
    task automatic step(input logic stb, input logic aen, input logic [N-1:0] det,
                        input logic [N-1:0] frc, input logic [2*N-1:0] md, input logic cb,
                        input logic [N-1:0] rx, input logic [N-1:0] m12,
                        input logic [N-1:0] ext, input string req);
        item_t it;
        @(negedge clk);
        frame_strobe = stb; auto_lb_en = aen; lb_det = det; force_lb = frc;
        slot_mode = md; cbit_mode = cb; rx_slot_data = rx; m12_data = m12;
        ext_ds2_data = ext;
        for (int y = 0; y < N; y++) begin
            if (stb) begin
                if (!cb && aen && det[y])      exp_src[y] = 2;
                else if (!cb && frc[y])        exp_src[y] = 3;
                else if (md[2*y +: 2] == 2'b0) exp_src[y] = 0;
                else                           exp_src[y] = 1;
            end
            it.code[2*y +: 2] = 2'(exp_src[y]);
            it.data[y] = (exp_src[y] == 0) ? m12[y] : (exp_src[y] == 1) ? ext[y] : rx[y];
        end
        it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: a quarter period after each edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                compare(it.req, it.code, it.data);
            end
        end
    end

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        mismatched++;
        $display("FAIL watchdog: run did not end, expected completion");
        summary();
    end

    initial begin
        for (int y = 0; y < N; y++) exp_src[y] = 0;
        // R1: reset state, with inputs and strobe active during reset
        @(negedge clk);
        frame_strobe = 1'b1; force_lb = '1; m12_data = '1; rx_slot_data = '1;
        repeat (2) @(negedge clk);
        compare("R1", '0, '0);
        frame_strobe = 1'b0; force_lb = '0; m12_data = '0; rx_slot_data = '0;
        rst_n = 1'b1;

        // R5 R6 R10: mixed modes per slot (slot1..7 = 00,01,10,11,00,01,10)
        step(1, 0, '0, '0, 14'b10_01_00_11_10_01_00, 0, 7'h00, 7'b1010101, 7'b0110011, "R6");
        step(0, 0, '0, '0, 14'b10_01_00_11_10_01_00, 0, 7'h7f, 7'b0101010, 7'b1001100, "R9");
        // R8: new controls without strobe, codes hold
        step(0, 1, '1, '1, 14'h0000, 0, 7'b1110000, 7'b0001111, 7'b1100110, "R8");
        step(0, 0, '0, '0, 14'h3fff, 0, 7'b0000111, 7'b1111000, 7'b0011001, "R8");
        // R5: all slots mode 00
        step(1, 0, '0, '0, 14'h0000, 0, 7'h00, 7'b1100101, 7'h7f, "R5");
        step(0, 0, '0, '0, 14'h0000, 0, 7'h7f, 7'b0011010, 7'h00, "R9");
        // R2: automatic loopback on slots 1 and 3
        step(1, 1, 7'b0000101, '0, 14'h0000, 0, 7'b0000101, 7'h00, 7'h7f, "R2");
        // R2 negative: detect flags without global enable
        step(1, 0, 7'b1111111, '0, 14'h1555, 0, 7'h7f, 7'h00, 7'b0110110, "R2");
        // R3: forced loopback on slots 2 and 5
        step(1, 0, '0, 7'b0010010, 14'h2aaa, 0, 7'b0010010, 7'h7f, 7'h00, "R3");
        step(0, 0, '0, 7'b0010010, 14'h2aaa, 0, 7'b0000000, 7'h7f, 7'h00, "R9");
        // R4: auto and forced on slot 1, auto only on slot 4, forced only on slot 7
        step(1, 1, 7'b0001001, 7'b1000001, 14'h0000, 0, 7'b1001001, 7'h00, 7'h00, "R4");
        // R7: same loopback requests in C-bit parity mode fall back to modes
        step(1, 1, 7'b0001001, 7'b1000001, 14'b11_00_00_01_00_00_00, 1, 7'h7f, 7'b0110110, 7'b1001001, "R7");
        step(1, 1, '1, '1, 14'h3fff, 1, 7'h7f, 7'h00, 7'b1010101, "R7");
        // R8: leave C-bit mode without strobe, codes hold
        step(0, 1, '1, '1, 14'h3fff, 0, 7'h00, 7'h7f, 7'b0101010, "R8");
        // R2 R10: all slots automatic loopback
        step(1, 1, '1, '0, 14'h1555, 0, 7'b1011001, 7'h00, 7'h7f, "R2");
        step(0, 0, '0, '0, 14'h0000, 0, 7'b0100110, 7'h7f, 7'h00, "R9");
        repeat (3) @(negedge clk);
        summary();
    end

endmodule